// File: doc/BRIEF.md
# Workgroup Completion and Signal Tracker

This block keeps a per-kernel record of finished workgroups and compares it with a total that is programmed when the kernel is set up. Each workgroup-complete strobe increments the kernel's count. When the count reaches the total, the block emits a one-cycle finish pulse that carries the kernel id and its queue id, and it retires the table entry. The same table holds a counter of outstanding cache write-back requests for each kernel. That counter is moved by single-step increment and decrement strobes, and each update reports whether the counter is now zero.

A kernel can carry a completion signal handle. When such a kernel finishes, the block decrements the 64-bit word that sits 8 bytes above the handle. It does this with a plain read followed by a write on a simple request/grant/response memory port. Finishing kernels that have handles are queued, so the read-modify-write engine serves them one at a time in finish order and loses none. A combinational query tells the scheduler whether the next completion of a chosen kernel will be its last. Every accepted completion also raises a level dispatch request, which stays up until the scheduler acknowledges it.

Top module: `wg_done_tracker`

## Requirements
- R1: A table write makes the entry valid, clears its completed count to zero, and stores the total, the handle, the handle-present flag and the queue id. If a table write and a completion target the same kernel in the same cycle, the write wins and the completion is discarded without error.
- R2: A completion strobe for a valid kernel raises that kernel's completed count by exactly one.
- R3: In the cycle after the completion that makes the count equal the total, `fin_pulse` is high for one cycle with `fin_kid` and `fin_qid` of that kernel. The entry then becomes invalid.
- R4: For a finished kernel that has a handle, the engine reads address handle+8 (`mem_we`=0). It then writes the value read minus one to that same address (`mem_we`=1).
- R5: A kernel that finishes without a handle causes no memory request.
- R6: `qry_last` is high exactly when the queried entry is valid and its completed count plus one equals its total.
- R7: A write-back strobe adds one when `wb_dec`=0 and subtracts one when `wb_dec`=1. A decrement at zero leaves the count at zero. In the next cycle `wb_rsp_vld` is high and `wb_rsp_zero` shows whether the new count is zero.
- R8: An accepted completion sets `disp_req`, which stays high until `disp_ack`. When an ack and an accepted completion arrive together, `disp_req` stays high.
- R9: Finishes with handles that occur while the engine is busy are queued. Every one of them is served, in finish order.
- R10: A completion for an invalid kernel entry sets the sticky `err_flag` and has no other effect: no count change, no finish and no dispatch request.
- R11: While `mem_req` is high and `mem_gnt` is low, the request, address, write enable and write data hold steady.
- R12: After reset, every entry is invalid and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_kid | input | KID_W | Kernel id to write |
| tbl_total | input | CNT_W | Workgroup total |
| tbl_handle | input | ADDR_W | Completion signal handle |
| tbl_sig_en | input | 1 | Handle present |
| tbl_qid | input | QID_W | Queue id |
| wg_done | input | 1 | Workgroup-complete strobe |
| wg_kid | input | KID_W | Kernel id of the completion |
| wb_upd | input | 1 | Write-back counter update strobe |
| wb_kid | input | KID_W | Kernel id of the update |
| wb_dec | input | 1 | 1 = decrement, 0 = increment |
| wb_rsp_vld | output | 1 | Update response valid |
| wb_rsp_zero | output | 1 | Updated count is zero |
| qry_kid | input | KID_W | Kernel id to query |
| qry_last | output | 1 | Next completion is the final one |
| fin_pulse | output | 1 | Kernel finished |
| fin_kid | output | KID_W | Finished kernel id |
| fin_qid | output | QID_W | Finished kernel queue id |
| disp_req | output | 1 | Dispatch pass requested |
| disp_ack | input | 1 | Dispatch request taken |
| err_flag | output | 1 | Sticky invalid-completion error |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | SIG_W | Memory write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rsp | input | 1 | Response (read data or write done) |
| mem_rdata | input | SIG_W | Read data |

## Verification
The bound checker checks the following on every cycle:
- the memory request holds steady while it is stalled;
- each write carries the last value read minus one;
- each finish pulse follows a completion strobe for the same id;
- the error flag never clears;
- each write-back strobe is answered in the next cycle;
- the finish queue never overflows.

Only the bench's scenarios can show the rest: the exact count at which a kernel finishes, the query result as counts advance, the service order of queued signal updates against a slow memory, the correct final signal values, the missing memory traffic for kernels without a handle, and the priority between a dispatch acknowledge and a completion.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
   typedef enum logic [2:0] {
      RMW_IDLE    = 3'd0,
      RMW_READ    = 3'd1,
      RMW_WAIT_RD = 3'd2,
      RMW_WRITE   = 3'd3,
      RMW_WAIT_WR = 3'd4
   } rmw_state_e;
endpackage

// File: rtl/wgt_table.sv
module wgt_table #(
   parameter int KID_W  = 3,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 64,
   parameter int QID_W  = 4,
   parameter int WB_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [KID_W-1:0]  tbl_kid,
   input  logic [CNT_W-1:0]  tbl_total,
   input  logic [ADDR_W-1:0] tbl_handle,
   input  logic              tbl_sig_en,
   input  logic [QID_W-1:0]  tbl_qid,
   input  logic              wg_done,
   input  logic [KID_W-1:0]  wg_kid,
   input  logic              wb_upd,
   input  logic [KID_W-1:0]  wb_kid,
   input  logic              wb_dec,
   input  logic [KID_W-1:0]  qry_kid,
   output logic              qry_last,
   output logic              cpl_hit,
   output logic              cpl_last,
   output logic              cpl_bad,
   output logic              cpl_sig,
   output logic [ADDR_W-1:0] cpl_handle,
   output logic [QID_W-1:0]  cpl_qid,
   output logic              wb_new_zero
);
   localparam int NKERN = 1 << KID_W;

   logic              vld_q    [NKERN];
   logic [CNT_W-1:0]  cnt_q    [NKERN];
   logic [CNT_W-1:0]  tot_q    [NKERN];
   logic [ADDR_W-1:0] handle_q [NKERN];
   logic              sig_q    [NKERN];
   logic [QID_W-1:0]  qid_q    [NKERN];
   logic [WB_W-1:0]   wb_q     [NKERN];

   logic              coll;
   logic [CNT_W:0]    cnt_inc;
   logic [CNT_W:0]    qry_inc;
   logic [WB_W-1:0]   wb_cur;
   logic [WB_W-1:0]   wb_nxt;

   always_comb begin
      coll       = tbl_we && (tbl_kid == wg_kid);
      cpl_hit    = wg_done && !coll && vld_q[wg_kid];
      cpl_bad    = wg_done && !coll && !vld_q[wg_kid];
      cnt_inc    = {1'b0, cnt_q[wg_kid]} + {{CNT_W{1'b0}}, 1'b1};
      cpl_last   = cpl_hit && (cnt_inc == {1'b0, tot_q[wg_kid]});
      cpl_sig    = sig_q[wg_kid];
      cpl_handle = handle_q[wg_kid];
      cpl_qid    = qid_q[wg_kid];
      qry_inc    = {1'b0, cnt_q[qry_kid]} + {{CNT_W{1'b0}}, 1'b1};
      qry_last   = vld_q[qry_kid] && (qry_inc == {1'b0, tot_q[qry_kid]});
   end

   always_comb begin
      wb_cur = wb_q[wb_kid];
      if (wb_dec) begin
         wb_nxt = (wb_cur == '0) ? '0 : wb_cur - WB_W'(1);
      end else begin
         wb_nxt = (wb_cur == '1) ? wb_cur : wb_cur + WB_W'(1);
      end
      wb_new_zero = (wb_nxt == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NKERN; k++) begin
            vld_q[k]    <= 1'b0;
            cnt_q[k]    <= '0;
            tot_q[k]    <= '0;
            handle_q[k] <= '0;
            sig_q[k]    <= 1'b0;
            qid_q[k]    <= '0;
            wb_q[k]     <= '0;
         end
      end else begin
         for (int k = 0; k < NKERN; k++) begin
            if (tbl_we && (tbl_kid == KID_W'(k))) begin
               vld_q[k]    <= 1'b1;
               cnt_q[k]    <= '0;
               tot_q[k]    <= tbl_total;
               handle_q[k] <= tbl_handle;
               sig_q[k]    <= tbl_sig_en;
               qid_q[k]    <= tbl_qid;
            end else if (cpl_hit && (wg_kid == KID_W'(k))) begin
               cnt_q[k] <= cnt_inc[CNT_W-1:0];
               if (cpl_last) begin
                  vld_q[k] <= 1'b0;
               end
            end
            if (wb_upd && (wb_kid == KID_W'(k))) begin
               wb_q[k] <= wb_nxt;
            end
         end
      end
   end
endmodule

// File: rtl/wgt_fifo.sv
module wgt_fifo #(
   parameter int W     = 64,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         logic         occ_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               slot_q <= '0;
               occ_q  <= 1'b0;
            end else if (push && !occ_q) begin
               slot_q <= wdata;
               occ_q  <= 1'b1;
            end else if (pop && occ_q) begin
               occ_q <= 1'b0;
            end
         end
         assign rdata = slot_q;
         assign empty = !occ_q;
         assign full  = occ_q;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         localparam int CW = $clog2(DEPTH + 1);
         logic [W-1:0]  mem_q [DEPTH];
         logic [PW-1:0] wp_q, rp_q;
         logic [CW-1:0] cnt_q;
         logic          do_push, do_pop;

         assign do_push = push && (cnt_q != CW'(DEPTH));
         assign do_pop  = pop && (cnt_q != '0);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else begin
               if (do_push) begin
                  mem_q[wp_q] <= wdata;
                  wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
               end
               if (do_pop) begin
                  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
               end
               if (do_push && !do_pop) cnt_q <= cnt_q + CW'(1);
               else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
            end
         end
         assign rdata = mem_q[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CW'(DEPTH));
      end
   endgenerate
endmodule

// File: rtl/wgt_sig_rmw.sv
module wgt_sig_rmw
   import wgt_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int SIG_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              job_vld,
   input  logic [ADDR_W-1:0] job_addr,
   output logic              job_pop,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [SIG_W-1:0]  mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rsp,
   input  logic [SIG_W-1:0]  mem_rdata
);
   rmw_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [SIG_W-1:0]  data_q;

   assign job_pop   = (st_q == RMW_IDLE) && job_vld;
   assign mem_req   = (st_q == RMW_READ) || (st_q == RMW_WRITE);
   assign mem_we    = (st_q == RMW_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RMW_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         unique case (st_q)
            RMW_IDLE: if (job_vld) begin
               addr_q <= job_addr;
               st_q   <= RMW_READ;
            end
            RMW_READ:    if (mem_gnt) st_q <= RMW_WAIT_RD;
            RMW_WAIT_RD: if (mem_rsp) begin
               data_q <= mem_rdata - SIG_W'(1);
               st_q   <= RMW_WRITE;
            end
            RMW_WRITE:   if (mem_gnt) st_q <= RMW_WAIT_WR;
            RMW_WAIT_WR: if (mem_rsp) st_q <= RMW_IDLE;
            default:     st_q <= RMW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wg_done_tracker.sv
module wg_done_tracker #(
   parameter int KID_W   = 3,
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 64,
   parameter int QID_W   = 4,
   parameter int WB_W    = 8,
   parameter int SIG_W   = 64,
   parameter int SIG_OFS = 8,
   parameter int Q_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tbl_we,
   input  logic [KID_W-1:0]  tbl_kid,
   input  logic [CNT_W-1:0]  tbl_total,
   input  logic [ADDR_W-1:0] tbl_handle,
   input  logic              tbl_sig_en,
   input  logic [QID_W-1:0]  tbl_qid,
   input  logic              wg_done,
   input  logic [KID_W-1:0]  wg_kid,
   input  logic              wb_upd,
   input  logic [KID_W-1:0]  wb_kid,
   input  logic              wb_dec,
   output logic              wb_rsp_vld,
   output logic              wb_rsp_zero,
   input  logic [KID_W-1:0]  qry_kid,
   output logic              qry_last,
   output logic              fin_pulse,
   output logic [KID_W-1:0]  fin_kid,
   output logic [QID_W-1:0]  fin_qid,
   output logic              disp_req,
   input  logic              disp_ack,
   output logic              err_flag,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [SIG_W-1:0]  mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rsp,
   input  logic [SIG_W-1:0]  mem_rdata
);
   generate
      if (KID_W < 1 || KID_W > 8) begin : g_bad_kid
         $error("wg_done_tracker: KID_W out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wg_done_tracker: CNT_W must be positive");
      end
      if (Q_DEPTH < 1) begin : g_bad_depth
         $error("wg_done_tracker: Q_DEPTH must be positive");
      end
      if (SIG_W < 8 || ADDR_W < 8) begin : g_bad_width
         $error("wg_done_tracker: SIG_W and ADDR_W must be at least 8");
      end
   endgenerate

   logic              cpl_hit, cpl_last, cpl_bad, cpl_sig;
   logic [ADDR_W-1:0] cpl_handle;
   logic [QID_W-1:0]  cpl_qid;
   logic              wb_new_zero;
   logic              push_w, pop_w, empty_w, full_w;
   logic [ADDR_W-1:0] job_addr;

   wgt_table #(
      .KID_W(KID_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .QID_W(QID_W), .WB_W(WB_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .tbl_we(tbl_we), .tbl_kid(tbl_kid), .tbl_total(tbl_total),
      .tbl_handle(tbl_handle), .tbl_sig_en(tbl_sig_en), .tbl_qid(tbl_qid),
      .wg_done(wg_done), .wg_kid(wg_kid),
      .wb_upd(wb_upd), .wb_kid(wb_kid), .wb_dec(wb_dec),
      .qry_kid(qry_kid), .qry_last(qry_last),
      .cpl_hit(cpl_hit), .cpl_last(cpl_last), .cpl_bad(cpl_bad), .cpl_sig(cpl_sig),
      .cpl_handle(cpl_handle), .cpl_qid(cpl_qid), .wb_new_zero(wb_new_zero)
   );

   assign push_w = cpl_last && cpl_sig;

   wgt_fifo #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push_w), .wdata(cpl_handle + ADDR_W'(SIG_OFS)),
      .pop(pop_w), .rdata(job_addr), .empty(empty_w), .full(full_w)
   );

   wgt_sig_rmw #(.ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_rmw (
      .clk(clk), .rst_n(rst_n),
      .job_vld(!empty_w), .job_addr(job_addr), .job_pop(pop_w),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rsp(mem_rsp),
      .mem_rdata(mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fin_pulse   <= 1'b0;
         fin_kid     <= '0;
         fin_qid     <= '0;
         wb_rsp_vld  <= 1'b0;
         wb_rsp_zero <= 1'b0;
         disp_req    <= 1'b0;
         err_flag    <= 1'b0;
      end else begin
         fin_pulse  <= cpl_last;
         if (cpl_last) begin
            fin_kid <= wg_kid;
            fin_qid <= cpl_qid;
         end
         wb_rsp_vld  <= wb_upd;
         wb_rsp_zero <= wb_upd && wb_new_zero;
         if (cpl_hit) disp_req <= 1'b1;
         else if (disp_ack) disp_req <= 1'b0;
         if (cpl_bad) err_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
   parameter int KID_W  = 3,
   parameter int ADDR_W = 64,
   parameter int SIG_W  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wg_done,
   input logic [KID_W-1:0]  wg_kid,
   input logic              wb_upd,
   input logic              wb_rsp_vld,
   input logic              fin_pulse,
   input logic [KID_W-1:0]  fin_kid,
   input logic              disp_req,
   input logic              err_flag,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [SIG_W-1:0]  mem_wdata,
   input logic              mem_gnt,
   input logic              mem_rsp,
   input logic [SIG_W-1:0]  mem_rdata,
   input logic              push_w,
   input logic              full_w
);
   logic             rd_pend, rd_have;
   logic [SIG_W-1:0] rd_val;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_pend <= 1'b0;
         rd_have <= 1'b0;
         rd_val  <= '0;
      end else begin
         if (mem_req && !mem_we && mem_gnt) rd_pend <= 1'b1;
         else if (rd_pend && mem_rsp) begin
            rd_pend <= 1'b0;
            rd_have <= 1'b1;
            rd_val  <= mem_rdata;
         end
         if (mem_req && mem_we && mem_gnt) rd_have <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R11
   AST_WRITE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> rd_have && (mem_wdata == rd_val - SIG_W'(1))); // R4
   AST_FIN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fin_pulse |-> $past(wg_done) && ($past(wg_kid) == fin_kid)); // R3
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R10
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(wg_done)); // R10
   AST_WB_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      wb_upd |=> wb_rsp_vld); // R7
   AST_DISP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_req) |-> $past(wg_done)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_w && full_w)); // R9
endmodule

bind wg_done_tracker wgt_checker #(.KID_W(KID_W), .ADDR_W(ADDR_W), .SIG_W(SIG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wg_done(wg_done), .wg_kid(wg_kid),
   .wb_upd(wb_upd), .wb_rsp_vld(wb_rsp_vld), .fin_pulse(fin_pulse),
   .fin_kid(fin_kid), .disp_req(disp_req), .err_flag(err_flag),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rsp(mem_rsp),
   .mem_rdata(mem_rdata), .push_w(push_w), .full_w(full_w)
);

// File: tb/sim_wg_done_tracker.sv
module sim_wg_done_tracker;
   localparam int CLK_NS = 10;

   logic        clk, rst_n;
   logic        tbl_we, tbl_sig_en;
   logic [2:0]  tbl_kid, wg_kid, wb_kid, qry_kid, fin_kid;
   logic [15:0] tbl_total;
   logic [63:0] tbl_handle, mem_addr, mem_wdata, mem_rdata;
   logic [3:0]  tbl_qid, fin_qid;
   logic        wg_done, wb_upd, wb_dec, wb_rsp_vld, wb_rsp_zero, qry_last;
   logic        fin_pulse, disp_req, disp_ack, err_flag;
   logic        mem_req, mem_we, mem_gnt, mem_rsp;

   wg_done_tracker u0 (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_kid(tbl_kid),
      .tbl_total(tbl_total), .tbl_handle(tbl_handle), .tbl_sig_en(tbl_sig_en),
      .tbl_qid(tbl_qid), .wg_done(wg_done), .wg_kid(wg_kid), .wb_upd(wb_upd),
      .wb_kid(wb_kid), .wb_dec(wb_dec), .wb_rsp_vld(wb_rsp_vld),
      .wb_rsp_zero(wb_rsp_zero), .qry_kid(qry_kid), .qry_last(qry_last),
      .fin_pulse(fin_pulse), .fin_kid(fin_kid), .fin_qid(fin_qid),
      .disp_req(disp_req), .disp_ack(disp_ack), .err_flag(err_flag),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rsp(mem_rsp),
      .mem_rdata(mem_rdata)
   );

   initial clk = 1'b0;
   always #(CLK_NS / 2) clk = ~clk;

   int n_chk = 0, n_fail = 0;

   bit          m_vld [8];
   int unsigned m_cnt [8], m_tot [8];
   logic [3:0]  m_qid [8];
   logic [63:0] m_hnd [8], m_init [8];
   bit          m_sig [8];
   int          m_wb [8];
   bit          e_fin, e_wbv, e_wbz, m_err, m_disp;
   logic [2:0]  e_fkid;
   logic [3:0]  e_fqid;
   logic [63:0] sig_q [$];
   logic [63:0] mem [logic [63:0]];
   int          rsp_cnt = 0, gcnt = 0;
   logic [63:0] rsp_data = '0;
   bit          prev_stall = 0, prev_we = 0;
   logic [63:0] prev_addr = '0, prev_wd = '0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cycle();
      bit acc, a_we, coll, hit, exp_q;
      logic [63:0] a_addr, a_wd;
      mem_rsp = (rsp_cnt == 1);
      mem_rdata = rsp_data;
      if (rsp_cnt > 0) rsp_cnt--;
      mem_gnt = (gcnt % 3) != 1;
      gcnt++;
      #1;
      exp_q = m_vld[qry_kid] && (m_cnt[qry_kid] + 1 == m_tot[qry_kid]);
      chk(qry_last == exp_q, "R6 query", 64'(qry_last), 64'(exp_q));
      chk(!(mem_req && sig_q.size() == 0), "R5 no request", 64'(mem_req), 0);
      if (prev_stall)
         chk(mem_req && mem_addr == prev_addr && mem_we == prev_we && mem_wdata == prev_wd,
             "R11 hold", mem_addr, prev_addr);
      prev_stall = mem_req && !mem_gnt;
      prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
      acc = mem_req && mem_gnt;
      a_we = mem_we; a_addr = mem_addr; a_wd = mem_wdata;
      if (acc && sig_q.size() > 0) begin
         chk(a_addr == sig_q[0], "R4 address", a_addr, sig_q[0]);
         if (a_we) chk(a_wd == mem[a_addr] - 64'd1, "R4 data", a_wd, mem[a_addr] - 64'd1);
      end
      @(posedge clk);
      e_fin = 0; e_wbv = 0; hit = 0;
      coll = tbl_we && (tbl_kid == wg_kid);
      if (wg_done && !coll) begin
         if (m_vld[wg_kid]) begin
            hit = 1;
            m_cnt[wg_kid]++;
            m_disp = 1;
            if (m_cnt[wg_kid] == m_tot[wg_kid]) begin
               e_fin = 1; e_fkid = wg_kid; e_fqid = m_qid[wg_kid];
               m_vld[wg_kid] = 0;
               if (m_sig[wg_kid]) sig_q.push_back(m_hnd[wg_kid] + 64'd8);
            end
         end else m_err = 1;
      end
      if (!hit && disp_ack) m_disp = 0;
      if (tbl_we) begin
         m_vld[tbl_kid] = 1; m_cnt[tbl_kid] = 0; m_tot[tbl_kid] = tbl_total;
         m_hnd[tbl_kid] = tbl_handle; m_sig[tbl_kid] = tbl_sig_en; m_qid[tbl_kid] = tbl_qid;
      end
      if (wb_upd) begin
         if (wb_dec) begin if (m_wb[wb_kid] > 0) m_wb[wb_kid]--; end
         else m_wb[wb_kid]++;
         e_wbv = 1; e_wbz = (m_wb[wb_kid] == 0);
      end
      if (acc) begin
         if (!a_we) rsp_data = mem[a_addr];
         else begin
            mem[a_addr] = a_wd;
            if (sig_q.size() > 0) void'(sig_q.pop_front());
         end
         rsp_cnt = 2;
      end
      @(negedge clk);
      chk(fin_pulse == e_fin, "R3 finish pulse", 64'(fin_pulse), 64'(e_fin));
      if (e_fin) begin
         chk(fin_kid == e_fkid, "R3 finish id", 64'(fin_kid), 64'(e_fkid));
         chk(fin_qid == e_fqid, "R3 queue id", 64'(fin_qid), 64'(e_fqid));
      end
      chk(wb_rsp_vld == e_wbv, "R7 response valid", 64'(wb_rsp_vld), 64'(e_wbv));
      if (e_wbv) chk(wb_rsp_zero == e_wbz, "R7 zero flag", 64'(wb_rsp_zero), 64'(e_wbz));
      chk(err_flag == m_err, "R10 error flag", 64'(err_flag), 64'(m_err));
      chk(disp_req == m_disp, "R8 dispatch request", 64'(disp_req), 64'(m_disp));
      tbl_we = 0; wg_done = 0; wb_upd = 0; disp_ack = 0;
   endtask

   task automatic prog(input int k, input int tot, input logic [63:0] hnd, input bit sig, input int q);
      tbl_we = 1; tbl_kid = 3'(k); tbl_total = 16'(tot); tbl_handle = hnd;
      tbl_sig_en = sig; tbl_qid = 4'(q);
      if (sig) begin
         m_init[k] = 64'h100 + 64'(k);
         mem[hnd + 64'd8] = m_init[k];
      end
      cycle();
   endtask

   task automatic done(input int k);
      wg_done = 1; wg_kid = 3'(k); qry_kid = 3'(k); cycle();
   endtask

   task automatic wb(input int k, input bit dec);
      wb_upd = 1; wb_kid = 3'(k); wb_dec = dec; cycle();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   initial begin
      #(CLK_NS * 20000);
      n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 0; tbl_we = 0; tbl_kid = 0; tbl_total = 0; tbl_handle = 0;
      tbl_sig_en = 0; tbl_qid = 0; wg_done = 0; wg_kid = 0; wb_upd = 0;
      wb_kid = 0; wb_dec = 0; qry_kid = 0; disp_ack = 0;
      mem_gnt = 0; mem_rsp = 0; mem_rdata = 0;
      for (int k = 0; k < 8; k++) begin
         m_vld[k] = 0; m_cnt[k] = 0; m_tot[k] = 0; m_wb[k] = 0; m_sig[k] = 0;
         m_qid[k] = 0; m_hnd[k] = 0; m_init[k] = 0;
      end
      m_err = 0; m_disp = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R12 reset state
      chk({fin_pulse, wb_rsp_vld, disp_req, err_flag, mem_req, qry_last} == 6'b0,
          "R12 reset outputs", 64'({fin_pulse, wb_rsp_vld, disp_req, err_flag, mem_req, qry_last}), 0);

      // R1, R2, R6: kernel 0, three workgroups, handle present
      qry_kid = 0;
      prog(0, 3, 64'h1000_0000, 1, 5);
      done(0);
      done(0);              // query now reports last
      done(0);              // R3 finish, R4 read-modify-write
      idle(12);

      // R5: kernel 1 has a single workgroup and no handle
      prog(1, 1, 64'h2000_0000, 0, 9);
      qry_kid = 1;
      cycle();              // R1: a total of one is the last immediately
      done(1);
      idle(4);

      // R9: three kernels finish back to back while the engine is busy
      prog(2, 1, 64'h3000_0000, 1, 1);
      prog(3, 1, 64'h3000_0100, 1, 2);
      prog(4, 2, 64'h3000_0200, 1, 3);
      done(4);
      done(2);
      done(3);
      done(4);
      idle(50);
      chk(sig_q.size() == 0, "R9 queue drained", 64'(sig_q.size()), 0);
      for (int k = 0; k < 5; k++)
         if (m_sig[k])
            chk(mem[m_hnd[k] + 64'd8] == m_init[k] - 64'd1, "R4 final signal",
                mem[m_hnd[k] + 64'd8], m_init[k] - 64'd1);

      // R7: write-back counter steps, including a decrement at zero
      wb(5, 0); wb(5, 0); wb(5, 1); wb(5, 1); wb(5, 1); wb(6, 1);

      // R8: acknowledge clears the request; an ack that meets a completion does not
      disp_ack = 1; cycle();
      prog(5, 4, 64'h4000_0000, 0, 7);
      done(5);
      disp_ack = 1; wg_done = 1; wg_kid = 5; cycle();
      disp_ack = 1; cycle();

      // R1: write and completion to the same kernel in one cycle; the write wins
      tbl_we = 1; tbl_kid = 5; tbl_total = 2; tbl_handle = 0; tbl_sig_en = 0; tbl_qid = 6;
      wg_done = 1; wg_kid = 5; qry_kid = 5; cycle();
      done(5); done(5);

      // R10: completions for invalid entries (never written, already finished)
      done(7);
      done(1);
      qry_kid = 7; idle(3);

      // R1: reprogramming a finished kernel brings it back
      prog(0, 1, 64'h5000_0000, 1, 4);
      done(0);
      idle(15);
      chk(mem[64'h5000_0008] == m_init[0] - 64'd1, "R4 reprogrammed signal",
          mem[64'h5000_0008], m_init[0] - 64'd1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule